// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block handles the receive side of up to two USB device OUT endpoints. Each endpoint owns a byte FIFO that the serial side fills through a push port. The serial side closes each packet with an end strobe that carries the byte count. When a packet closes, the endpoint holds it behind a packet-ready flag and refuses further traffic with a NAK indication until the flag drops. The packet is drained through a byte read port, either by the processor or by a DMA engine. Whether a packet raises a DMA request, an interrupt, or both depends on the endpoint's configuration and on whether the packet length matches the programmed maximum packet size.

Software reaches the per-endpoint registers through an index register. Index values 1 and 2 select the first and second endpoint, and any other value selects nothing. The flag can be dropped by a software write. It can also drop automatically on the read of the last byte of a maximum-size packet. Each endpoint runs a three-state machine. `EP_IDLE` moves to `EP_FILL` on a push or to `EP_READY` on an end strobe. `EP_FILL` moves to `EP_READY` on the end strobe. `EP_READY` returns to `EP_IDLE` on a software clear or an automatic clear. Leaving `EP_READY` resets the FIFO pointers.

Register offsets:

- 0x00: index, bits 3:0.
- 0x44: ready status. Bit 0 is the flag and bits 15:8 hold the stored length. Writing bit 0 = 0 clears the flag.
- 0x50: maximum packet size.
- 0x54: control. Bit 7 is auto-clear, bit 6 is isochronous, bit 5 is DMA enable and bit 4 is DMA mode.
- 0x58: interrupt status, one bit per endpoint (bit 0 = first endpoint), write 1 to clear.

Top module: `usb_out_rx`

## Requirements
- R1: After reset, every control field, maximum size, index, packet-ready flag, interrupt bit, `dma_req` and `irq` are 0.
- R2: The control register at 0x54 is reached only with index 1 or 2. Only bits 7:4 are stored and read back, and all other bits read 0. With any other index, it reads 0 and writes have no effect.
- R3: An end strobe sets the endpoint's packet-ready flag (0x44 bit 0) on the next clock edge. While the flag is set, a push or end strobe to that endpoint raises `rx_nak` in the same cycle, and the pushed byte is discarded.
- R4: With auto-clear (bit 7) set and a received length equal to the maximum size, the flag drops on the clock edge of the pop that reads the final byte.
- R5: If the packet is shorter than the maximum size, or auto-clear is 0, the flag stays set after the full drain. A write to 0x44 with bit 0 = 0 clears it.
- R6: With DMA enable (bit 5) = 1 and DMA mode (bit 4) = 0, every packet raises both `dma_req` and an interrupt.
- R7: With DMA enable = 1 and DMA mode = 1, a maximum-size packet raises `dma_req` and no interrupt, and any other length raises an interrupt and no `dma_req`.
- R8: With DMA enable = 0, `dma_req` stays 0 and every packet raises an interrupt. `dma_req` is only high while the flag is set.
- R9: Interrupt bits at 0x58 are sticky, are cleared by writing 1 to them, and `irq` is their OR.
- R10: `fifo_rdata` presents the packet's bytes in arrival order, advancing one byte per pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rx_push | input | 1 | Received byte valid |
| rx_end | input | 1 | Packet complete strobe |
| rx_ep | input | 1 | Target endpoint of push/end (0 = first) |
| rx_data | input | 8 | Received byte |
| rx_len | input | 7 | Packet byte count with `rx_end` |
| rx_nak | output | 1 | Traffic refused, endpoint still holds a packet |
| fifo_pop | input | 1 | Read one byte |
| fifo_ep | input | 1 | Endpoint being read |
| fifo_rdata | output | 8 | Byte at the read position |
| dma_req | output | 2 | Per-endpoint DMA request |
| irq | output | 1 | OR of interrupt status bits |

## Verification
Register reads and `rx_nak` are combinational, so they are due in the cycle the address or strobe is applied. The bench samples them a short delay after driving on the falling edge. The packet-ready flag, interrupt status and `dma_req` change on the rising edge that takes the end strobe. Auto-clear and software clear take effect on the rising edge of the final pop or of the write. The bench drives every stimulus on a falling edge and checks at the following falling edge, one register stage later. Drained bytes are sampled before the pop edge, so each comparison sees the byte that pop consumes.

// File: rtl/usb_out_rx_pkg.sv
package usb_out_rx_pkg;

    typedef enum logic [1:0] {
        EP_IDLE  = 2'd0,
        EP_FILL  = 2'd1,
        EP_READY = 2'd2
    } ep_state_e;

    typedef struct packed {
        logic auto_clr;
        logic iso;
        logic dma_en;
        logic dma_mode;
    } ep_cfg_t;

    localparam logic [7:0] OFS_INDEX = 8'h00;
    localparam logic [7:0] OFS_RDY   = 8'h44;
    localparam logic [7:0] OFS_MAXP  = 8'h50;
    localparam logic [7:0] OFS_CTRL  = 8'h54;
    localparam logic [7:0] OFS_IRQ   = 8'h58;

endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [LEN_W-1:0]  wptr;
    logic [AW-1:0]     rptr;
    logic              wr_ok;

    assign wr_ok   = wr_en && (wptr < LEN_W'(DEPTH));
    assign rd_data = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr[AW-1:0]] <= wr_data;
    end
endmodule

// File: rtl/ep_ctrl.sv
module ep_ctrl
    import usb_out_rx_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  ep_cfg_t          cfg_in,
    input  logic             maxp_we,
    input  logic [LEN_W-1:0] maxp_in,
    input  logic             sw_clr,
    input  logic             rx_push,
    input  logic             rx_end,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             pop,
    output ep_cfg_t          cfg,
    output logic [LEN_W-1:0] maxp,
    output logic [LEN_W-1:0] pkt_len,
    output logic             ready,
    output logic             fifo_wr,
    output logic             fifo_rd,
    output logic             fifo_clr,
    output logic             nak,
    output logic             dma_req,
    output logic             irq_evt
);
    ep_state_e        state, state_nx;
    logic [LEN_W-1:0] rd_cnt;
    logic             pkt_is_max;
    logic             len_is_max;
    logic             last_pop;
    logic             auto_done;

    assign len_is_max = (rx_len == maxp);
    assign last_pop   = (rd_cnt + 1'b1 == pkt_len);
    assign auto_done  = (state == EP_READY) && fifo_rd && cfg.auto_clr
                        && pkt_is_max && last_pop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            EP_IDLE: begin
                if (rx_end)       state_nx = EP_READY;
                else if (rx_push) state_nx = EP_FILL;
            end
            EP_FILL: begin
                if (rx_end) state_nx = EP_READY;
            end
            EP_READY: begin
                if (sw_clr || auto_done) state_nx = EP_IDLE;
            end
            default: state_nx = EP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = (state == EP_READY);
        fifo_wr  = 1'b0;
        fifo_rd  = 1'b0;
        nak      = 1'b0;
        irq_evt  = 1'b0;
        dma_req  = 1'b0;
        fifo_clr = 1'b0;
        unique case (state)
            EP_IDLE, EP_FILL: begin
                fifo_wr = rx_push;
                irq_evt = rx_end && (!cfg.dma_en || !cfg.dma_mode || !len_is_max);
            end
            EP_READY: begin
                nak      = rx_push || rx_end;
                fifo_rd  = pop && (rd_cnt < pkt_len);
                dma_req  = cfg.dma_en && (!cfg.dma_mode || pkt_is_max);
                fifo_clr = sw_clr || auto_done;
            end
            default: ;
        endcase
    end

    // configuration and packet bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '0;
            maxp       <= '0;
            pkt_len    <= '0;
            pkt_is_max <= 1'b0;
            rd_cnt     <= '0;
        end else begin
            if (cfg_we)  cfg  <= cfg_in;
            if (maxp_we) maxp <= maxp_in;
            if (state != EP_READY && rx_end) begin
                pkt_len    <= rx_len;
                pkt_is_max <= len_is_max;
                rd_cnt     <= '0;
            end else if (fifo_rd) begin
                rd_cnt <= rd_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_out_rx.sv
module usb_out_rx
    import usb_out_rx_pkg::*;
#(
    parameter int NUM_EP     = 2,
    parameter int FIFO_DEPTH = 64,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = $clog2(FIFO_DEPTH + 1),
    parameter int EP_W       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_push,
    input  logic              rx_end,
    input  logic [EP_W-1:0]   rx_ep,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              rx_nak,
    input  logic              fifo_pop,
    input  logic [EP_W-1:0]   fifo_ep,
    output logic [DATA_W-1:0] fifo_rdata,
    output logic [NUM_EP-1:0] dma_req,
    output logic              irq
);
    logic [3:0]        index_q;
    logic [NUM_EP-1:0] irq_st;
    logic [NUM_EP-1:0] irq_evt;
    logic [NUM_EP-1:0] ep_ready;
    logic [NUM_EP-1:0] ep_nak;
    logic [NUM_EP-1:0] ep_sel;
    ep_cfg_t           ep_cfg  [NUM_EP];
    logic [LEN_W-1:0]  ep_maxp [NUM_EP];
    logic [LEN_W-1:0]  ep_len  [NUM_EP];
    logic [DATA_W-1:0] ep_data [NUM_EP];
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[31:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            irq_st  <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_INDEX) index_q <= reg_wdata[3:0];
            irq_st <= (irq_st & ~((reg_wr && reg_addr == OFS_IRQ)
                                  ? reg_wdata[NUM_EP-1:0] : '0)) | irq_evt;
        end
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic     rx_hit;
        logic     pop_hit;
        logic     fifo_wr;
        logic     fifo_rd;
        logic     fifo_clr;

        assign ep_sel[i] = (index_q == 4'(i + 1));
        assign rx_hit    = (rx_ep == EP_W'(i));
        assign pop_hit   = fifo_pop && (fifo_ep == EP_W'(i));

        ep_ctrl #(.LEN_W(LEN_W)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (reg_wr && ep_sel[i] && reg_addr == OFS_CTRL),
            .cfg_in   (ep_cfg_t'(reg_wdata[7:4])),
            .maxp_we  (reg_wr && ep_sel[i] && reg_addr == OFS_MAXP),
            .maxp_in  (reg_wdata[LEN_W-1:0]),
            .sw_clr   (reg_wr && ep_sel[i] && reg_addr == OFS_RDY && !reg_wdata[0]),
            .rx_push  (rx_push && rx_hit),
            .rx_end   (rx_end && rx_hit),
            .rx_len   (rx_len),
            .pop      (pop_hit),
            .cfg      (ep_cfg[i]),
            .maxp     (ep_maxp[i]),
            .pkt_len  (ep_len[i]),
            .ready    (ep_ready[i]),
            .fifo_wr  (fifo_wr),
            .fifo_rd  (fifo_rd),
            .fifo_clr (fifo_clr),
            .nak      (ep_nak[i]),
            .dma_req  (dma_req[i]),
            .irq_evt  (irq_evt[i])
        );

        ep_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (fifo_clr),
            .wr_en   (fifo_wr),
            .wr_data (rx_data),
            .rd_en   (fifo_rd),
            .rd_data (ep_data[i])
        );
    end

    assign rx_nak = |ep_nak;
    assign irq    = |irq_st;

    always_comb begin
        fifo_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (fifo_ep == EP_W'(i)) fifo_rdata = ep_data[i];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_INDEX: reg_rdata = 32'(index_q);
            OFS_IRQ:   reg_rdata = 32'(irq_st);
            default:   ;
        endcase
        for (int i = 0; i < NUM_EP; i++) begin
            if (ep_sel[i]) begin
                if (reg_addr == OFS_CTRL) reg_rdata = {24'd0, ep_cfg[i], 4'd0};
                if (reg_addr == OFS_MAXP) reg_rdata = 32'(ep_maxp[i]);
                if (reg_addr == OFS_RDY)
                    reg_rdata = (32'(ep_len[i]) << 8) | 32'(ep_ready[i]);
            end
        end
    end
endmodule

// File: rtl/usb_out_rx_chk.sv
module usb_out_rx_chk #(
    parameter int NUM_EP = 2,
    parameter int EP_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_push,
    input logic              rx_end,
    input logic [EP_W-1:0]   rx_ep,
    input logic              rx_nak,
    input logic              fifo_pop,
    input logic              reg_wr,
    input logic [NUM_EP-1:0] ep_ready,
    input logic [NUM_EP-1:0] irq_st,
    input logic [NUM_EP-1:0] dma_req
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
        // R3
        nak_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((rx_push || rx_end) && rx_ep == EP_W'(i) && ep_ready[i]) |-> rx_nak);
        // R3
        ready_from_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ep_ready[i]) |-> $past(rx_end));
        // R4
        ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ep_ready[i]) |-> $past(fifo_pop || reg_wr));
        // R8
        dma_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req[i] |-> ep_ready[i]);
        // R9
        irq_from_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_st[i]) |-> $past(rx_end));
    end
endmodule

bind usb_out_rx usb_out_rx_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_push  (rx_push),
    .rx_end   (rx_end),
    .rx_ep    (rx_ep),
    .rx_nak   (rx_nak),
    .fifo_pop (fifo_pop),
    .reg_wr   (reg_wr),
    .ep_ready (ep_ready),
    .irq_st   (irq_st),
    .dma_req  (dma_req)
);

// File: tb/tb_usb_out_rx.sv
module tb_usb_out_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_push = 1'b0;
    logic        rx_end = 1'b0;
    logic [0:0]  rx_ep = '0;
    logic [7:0]  rx_data = '0;
    logic [6:0]  rx_len = '0;
    logic        rx_nak;
    logic        fifo_pop = 1'b0;
    logic [0:0]  fifo_ep = '0;
    logic [7:0]  fifo_rdata;
    logic [1:0]  dma_req;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    usb_out_rx dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push),
        .rx_end(rx_end), .rx_ep(rx_ep), .rx_data(rx_data), .rx_len(rx_len),
        .rx_nak(rx_nak), .fifo_pop(fifo_pop), .fifo_ep(fifo_ep),
        .fifo_rdata(fifo_rdata), .dma_req(dma_req), .irq(irq)
    );

    // {ep, len, ctl{auto,iso,dma_en,mode}, maxp, exp_dma, exp_irq, exp_rdy_after_drain}
    localparam logic [21:0] VEC [6] = '{
        {1'b0, 7'd8, 4'b1000, 7'd8, 1'b0, 1'b1, 1'b0},
        {1'b1, 7'd5, 4'b1000, 7'd8, 1'b0, 1'b1, 1'b1},
        {1'b0, 7'd8, 4'b1011, 7'd8, 1'b1, 1'b0, 1'b0},
        {1'b1, 7'd3, 4'b0011, 7'd8, 1'b0, 1'b1, 1'b1},
        {1'b0, 7'd8, 4'b0010, 7'd8, 1'b1, 1'b1, 1'b1},
        {1'b1, 7'd4, 4'b1110, 7'd4, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_pkt(input logic ep, input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_push = 1'b1; rx_ep = ep; rx_data = base + 8'(i);
        end
        @(negedge clk);
        rx_push = 1'b0; rx_end = 1'b1; rx_ep = ep; rx_len = 7'(len);
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic pop_byte(input logic ep, output logic [7:0] d);
        @(negedge clk);
        fifo_ep = ep;
        #1 d = fifo_rdata;
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(8'h00, rd); chk("R1 index", rd, 0);
        reg_write(8'h00, 1);
        reg_read(8'h54, rd); chk("R1 ctrl", rd, 0);
        reg_read(8'h50, rd); chk("R1 maxp", rd, 0);
        reg_read(8'h44, rd); chk("R1 ready", rd, 0);
        reg_read(8'h58, rd); chk("R1 irq status", rd, 0);
        chk("R1 pins", {30'd0, dma_req} | 32'(irq), 0);

        // R2 reserved bits and index gating
        reg_write(8'h54, 32'hFFFF_FFFF);
        reg_read(8'h54, rd); chk("R2 reserved bits", rd, 32'hF0);
        reg_write(8'h54, 0);
        reg_write(8'h00, 0);
        reg_write(8'h54, 32'hF0);
        reg_read(8'h54, rd); chk("R2 index0 read", rd, 0);
        reg_write(8'h00, 3);
        reg_read(8'h54, rd); chk("R2 index3 read", rd, 0);
        reg_write(8'h00, 1);
        reg_read(8'h54, rd); chk("R2 index0 write ignored", rd, 0);
        reg_write(8'h00, 2);
        reg_read(8'h54, rd); chk("R2 ep2 untouched", rd, 0);

        // vector table
        for (int k = 0; k < 6; k++) begin
            logic       ep;
            int         len;
            logic [7:0] base;
            ep   = VEC[k][21];
            len  = int'(VEC[k][20:14]);
            base = 8'(16 * (k + 1));
            reg_write(8'h00, 32'(ep) + 1);
            reg_write(8'h50, 32'(VEC[k][9:3]));
            reg_write(8'h54, 32'(VEC[k][13:10]) << 4);
            send_pkt(ep, len, base);
            reg_read(8'h44, rd);
            chk($sformatf("R3 ready v%0d", k), rd, (32'(len) << 8) | 1);
            chk($sformatf("R6 R7 R8 dma v%0d", k), 32'(dma_req[ep]), 32'(VEC[k][2]));
            chk($sformatf("R9 irq pin v%0d", k), 32'(irq), 32'(VEC[k][1]));
            reg_read(8'h58, rd);
            chk($sformatf("R6 R7 irq bit v%0d", k), 32'(rd[ep]), 32'(VEC[k][1]));
            for (int i = 0; i < len; i++) begin
                pop_byte(ep, b);
                chk($sformatf("R10 byte v%0d i%0d", k, i), 32'(b), 32'(base + 8'(i)));
            end
            reg_read(8'h44, rd);
            chk($sformatf("R4 R5 ready after drain v%0d", k), 32'(rd[0]), 32'(VEC[k][0]));
            chk($sformatf("R8 dma after drain v%0d", k), 32'(dma_req[ep]),
                32'(VEC[k][2] & VEC[k][0]));
            if (VEC[k][0]) begin
                reg_write(8'h44, 0);
                reg_read(8'h44, rd);
                chk($sformatf("R5 sw clear v%0d", k), 32'(rd[0]), 0);
            end
            reg_write(8'h58, 3);
            chk($sformatf("R9 irq cleared v%0d", k), 32'(irq), 0);
        end

        // R3 NAK while full, pushed byte discarded
        reg_write(8'h00, 1);
        reg_write(8'h54, 0);
        send_pkt(1'b0, 2, 8'hA1);
        @(negedge clk);
        rx_push = 1'b1; rx_ep = 1'b0; rx_data = 8'hEE;
        #1 chk("R3 nak on full", 32'(rx_nak), 1);
        @(negedge clk);
        rx_push = 1'b0;
        pop_byte(1'b0, b); chk("R3 R10 first byte kept", 32'(b), 32'hA1);
        pop_byte(1'b0, b); chk("R3 R10 second byte kept", 32'(b), 32'hA2);

        // R9 both endpoints, partial clear
        reg_write(8'h00, 2);
        reg_write(8'h54, 0);
        send_pkt(1'b1, 1, 8'h55);
        @(negedge clk);
        rx_push = 1'b1; rx_ep = 1'b1;
        #1 chk("R3 nak ep2", 32'(rx_nak), 1);
        rx_ep = 1'b0;
        @(negedge clk);
        rx_push = 1'b0;
        reg_read(8'h58, rd); chk("R9 both pending", rd, 3);
        reg_write(8'h58, 1);
        reg_read(8'h58, rd); chk("R9 partial clear", rd, 2);
        chk("R9 irq still high", 32'(irq), 1);
        reg_write(8'h58, 2);
        chk("R9 irq low", 32'(irq), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule